// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Register Port

This block makes one pulse-width-modulated output from three 32-bit registers that software writes over a plain register port (address, write strobe, write data, read data). A free-running counter clocked by the peripheral clock walks from zero to one below the programmed period and then wraps. The output holds its active level while the count is below the programmed duty. Both counts are in peripheral clock cycles, so software converts a time into a count by multiplying the time by the clock rate.

A control word sets the run state and the output gate. It also selects inverted polarity and a one-shot mode, enables the interrupt, and holds the end-of-period flag and a counter restart strobe. Every change of configuration takes effect in the next cycle. The block never waits for the end of the current period: stopping cuts the output at once, and a new duty or period restarts the count from zero.

Top module: `pwm_unit`

## Requirements
- R1: Byte offset 0x4 holds the duty count, 0x8 the period count and 0xC the control word. All three read back what was written and read 0 after reset. Any other offset reads 0. Control fields that read back: bit 0 run, bit 3 output gate (active low), bit 4 one-shot, bit 5 interrupt enable, bit 6 end-of-period flag, bit 9 invert. All other control bits read 0.
- R2: While running, the count after the k-th clock edge that follows the run-enabling write is k mod period. With invert clear, the output is 1 exactly when that count is below duty.
- R3: With control bit 9 set, the output is 0 exactly when the count is below duty and 1 otherwise.
- R4: When duty is greater than or equal to a nonzero period, the active level lasts the whole period.
- R5: A period of zero forces the output to 0 whatever the duty and the invert bit. With duty and period both zero the output is constant 0.
- R6: While control bit 0 is clear, the output is 0 whatever the invert bit. Clearing it during a period forces the output to 0 in the next cycle.
- R7: While control bit 3 is 1, the output is 0 even when running.
- R8: A write to the duty or period register restarts the count at 0 on the same edge. The old period is abandoned.
- R9: Writing control with bit 7 set restarts the count at 0. Bit 7 always reads back 0.
- R10: The flag (control bit 6) is set on the edge where the count wraps from period-1 to 0. Writing 1 to bit 6 clears it. A wrap on the same edge wins.
- R11: The irq output is 1 exactly when the flag and the interrupt enable (bit 5) are both set.
- R12: With one-shot mode (bit 4) set, the block clears the run bit itself at the first wrap. The output is then 0 from the next cycle and the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock, also the count clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Interrupt request, level |

## Verification
A counter that drifts shows up at once as a shifted edge on pwm_out. It also changes the cycle in which irq rises, because the flag depends on the wrap cycle. The bench checks both ports every cycle against the k mod period rule, so a phase slip or a missed restart fails within one period. A run or gate bit in the wrong state shows in the cycle after the write that should have changed it: a stopped block stays 0 and a gated block stays 0. A one-shot run that fails to stop is caught in the first cycle after the wrap and again when the control word is read back.

// File: rtl/pwm_unit_pkg.sv
// Shared constants and types for the PWM peripheral.
// Assumes byte offsets on a 4-bit address and 32-bit registers.
package pwm_unit_pkg;
    localparam int unsigned OFS_DUTY   = 4;
    localparam int unsigned OFS_PERIOD = 8;
    localparam int unsigned OFS_CTRL   = 12;

    localparam int unsigned BIT_RUN     = 0;
    localparam int unsigned BIT_GATE_N  = 3;
    localparam int unsigned BIT_ONESHOT = 4;
    localparam int unsigned BIT_IE      = 5;
    localparam int unsigned BIT_FLAG    = 6;
    localparam int unsigned BIT_RESTART = 7;
    localparam int unsigned BIT_INV     = 9;

    typedef struct packed {
        logic inv;
        logic flag;
        logic ie;
        logic oneshot;
        logic gate_n;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
// Register file: duty, period and control word, plus read mux.
// Assumes one write per cycle; hardware wrap events override software
// flag clears, and a software control write overrides the one-shot stop.
module pwm_regs
    import pwm_unit_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wrap_i,
    output logic [DATA_W-1:0] duty_o,
    output logic [DATA_W-1:0] period_o,
    output ctrl_t             ctrl_o,
    output logic              restart_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic              wr_duty, wr_period, wr_ctrl;
    logic [DATA_W-1:0] duty_q, period_q;
    ctrl_t             ctrl_q, ctrl_d;
    logic [DATA_W-1:0] ctrl_view;

    // Decode which register a write targets.
    always_comb begin
        wr_duty   = we_i && (addr_i == ADDR_W'(OFS_DUTY));
        wr_period = we_i && (addr_i == ADDR_W'(OFS_PERIOD));
        wr_ctrl   = we_i && (addr_i == ADDR_W'(OFS_CTRL));
    end

    // Any new count value or an explicit restart strobe restarts the counter.
    assign restart_o = wr_duty || wr_period || (wr_ctrl && wdata_i[BIT_RESTART]);

    // Next control word: one-shot stop, software write, then flag set.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wrap_i && ctrl_q.oneshot) ctrl_d.run = 1'b0;
        if (wr_ctrl) begin
            ctrl_d.run     = wdata_i[BIT_RUN];
            ctrl_d.gate_n  = wdata_i[BIT_GATE_N];
            ctrl_d.oneshot = wdata_i[BIT_ONESHOT];
            ctrl_d.ie      = wdata_i[BIT_IE];
            ctrl_d.inv     = wdata_i[BIT_INV];
            if (wdata_i[BIT_FLAG]) ctrl_d.flag = 1'b0;
        end
        if (wrap_i) ctrl_d.flag = 1'b1;
    end

    // Hold the three registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q   <= '0;
            period_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (wr_duty)   duty_q   <= wdata_i;
            if (wr_period) period_q <= wdata_i;
            ctrl_q <= ctrl_d;
        end
    end

    // Place control fields at their bit positions for read-back.
    always_comb begin
        ctrl_view              = '0;
        ctrl_view[BIT_RUN]     = ctrl_q.run;
        ctrl_view[BIT_GATE_N]  = ctrl_q.gate_n;
        ctrl_view[BIT_ONESHOT] = ctrl_q.oneshot;
        ctrl_view[BIT_IE]      = ctrl_q.ie;
        ctrl_view[BIT_FLAG]    = ctrl_q.flag;
        ctrl_view[BIT_INV]     = ctrl_q.inv;
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        if (addr_i == ADDR_W'(OFS_DUTY))        rdata_o = duty_q;
        else if (addr_i == ADDR_W'(OFS_PERIOD)) rdata_o = period_q;
        else if (addr_i == ADDR_W'(OFS_CTRL))   rdata_o = ctrl_view;
        else                                    rdata_o = '0;
    end

    assign duty_o   = duty_q;
    assign period_o = period_q;
    assign ctrl_o   = ctrl_q;

    p_flag_on_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> ctrl_q.flag)
        else $error("flag not set after wrap");

    p_oneshot_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && ctrl_q.oneshot && !wr_ctrl) |=> !ctrl_q.run)
        else $error("one-shot did not stop");
endmodule

// File: rtl/pwm_counter.sv
// Period counter: counts 0..period-1 while running and reports the wrap.
// Assumes period 0 means idle; restart beats wrap on the same edge.
module pwm_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [DATA_W-1:0] period_i,
    output logic [DATA_W-1:0] count_o,
    output logic              wrap_o
);
    logic [DATA_W-1:0] count_q;
    logic              at_last;

    // Last count of the period; >= also covers any period shrink.
    assign at_last = (period_i != '0) && (count_q >= period_i - DATA_W'(1));
    assign wrap_o  = run_i && !restart_i && at_last;

    // Advance, wrap, or hold at zero when stopped or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n)                          count_q <= '0;
        else if (restart_i || !run_i)        count_q <= '0;
        else if (period_i == '0 || at_last)  count_q <= '0;
        else                                 count_q <= count_q + DATA_W'(1);
    end

    assign count_o = count_q;

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i != '0) |-> (count_q < period_i))
        else $error("count beyond period");

    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (count_q == '0))
        else $error("restart did not clear count");

    p_stop_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (count_q == '0))
        else $error("stopped counter not at zero");
endmodule

// File: rtl/pwm_outstage.sv
// Output stage: compares count with duty, applies polarity and gating.
// Assumes all inputs come from flops; output is combinational.
module pwm_outstage #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              run_i,
    input  logic              gate_n_i,
    input  logic              inv_i,
    input  logic [DATA_W-1:0] duty_i,
    input  logic [DATA_W-1:0] period_i,
    input  logic [DATA_W-1:0] count_i,
    output logic              pwm_o
);
    logic live, active, level;

    // Active phase, polarity, then the run/gate/zero-period mask.
    always_comb begin
        live   = run_i && !gate_n_i && (period_i != '0);
        active = count_i < duty_i;
        level  = active ^ inv_i;
        pwm_o  = live && level;
    end
endmodule

// File: rtl/pwm_unit.sv
// Top of the PWM peripheral: registers, counter and output stage.
// Assumes a synchronous active-low reset and a single clock domain.
module pwm_unit
    import pwm_unit_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out,
    output logic              irq
);
    logic [DATA_W-1:0] duty, period, count;
    ctrl_t             ctrl;
    logic              restart, wrap;

    pwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
        .wdata_i(bus_wdata), .wrap_i(wrap), .duty_o(duty), .period_o(period),
        .ctrl_o(ctrl), .restart_o(restart), .rdata_o(bus_rdata)
    );

    pwm_counter #(.DATA_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run_i(ctrl.run), .restart_i(restart),
        .period_i(period), .count_o(count), .wrap_o(wrap)
    );

    pwm_outstage #(.DATA_W(DATA_W)) u_out (
        .run_i(ctrl.run), .gate_n_i(ctrl.gate_n), .inv_i(ctrl.inv),
        .duty_i(duty), .period_i(period), .count_i(count), .pwm_o(pwm_out)
    );

    // Interrupt request is the flag qualified by its enable.
    assign irq = ctrl.flag && ctrl.ie;

    p_zero_period_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |-> !pwm_out)
        else $error("output active with zero period");

    p_stopped_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> !pwm_out)
        else $error("output active while stopped");

    p_gated_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.gate_n |-> !pwm_out)
        else $error("output active while gated");

    p_irq_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl.ie && ctrl.flag))
        else $error("irq without enable and flag");
endmodule

// File: tb/pwm_unit_tb.sv
// Scoreboard bench: driver pushes per-cycle expectations, monitor compares.
module pwm_unit_tb;
    typedef struct {
        logic  pwm;
        logic  irq;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out, irq;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    pwm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
    );

    always #2 clk = ~clk;

    // Monitor: one expectation per cycle, sampled 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (pwm_out !== e.pwm || irq !== e.irq) begin
                n_bad++;
                $display("FAIL %s: pwm/irq got %b/%b expected %b/%b at %0t",
                         e.tag, pwm_out, irq, e.pwm, e.irq, $time);
            end
        end
    end

    task automatic push(input logic p, input logic i, input string tag);
        exp_t e;
        e.pwm = p; e.irq = i; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic set_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    endtask

    task automatic end_write(input int n);
        @(negedge clk);
        bus_we = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        set_write(a, d);
        end_write(1);
    endtask

    task automatic check_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        n_cmp++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: read 0x%0h got 0x%0h expected 0x%0h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic check_port(input logic got, input logic exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: port got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and unmapped read
        check_read(4'h4, 32'h0, "R1");
        check_read(4'h8, 32'h0, "R1");
        check_read(4'hC, 32'h0, "R1");
        check_read(4'h0, 32'h0, "R1");
        check_port(pwm_out, 1'b0, "R1");
        check_port(irq, 1'b0, "R1");

        // R2, R10, R11: normal polarity, duty 3 of 8, interrupt enabled
        write_reg(4'h4, 32'd3);
        write_reg(4'h8, 32'd8);
        check_read(4'h4, 32'd3, "R1");
        check_read(4'h8, 32'd8, "R1");
        set_write(4'hC, 32'h61);
        for (int k = 0; k < 20; k++) push((k % 8) < 3, k >= 8, "R2");
        end_write(20);

        // R3, R9: invert with explicit restart
        set_write(4'hC, 32'h2E1);
        for (int k = 0; k < 20; k++) push(!((k % 8) < 3), k >= 8, "R3");
        end_write(20);
        check_read(4'hC, 32'h261, "R9");

        // R8: period change while running restarts immediately
        set_write(4'h8, 32'd5);
        for (int k = 0; k < 12; k++) push(!((k % 5) < 3), 1'b1, "R8");
        end_write(12);

        // R6: stop mid-period, invert still set, output forced low
        set_write(4'hC, 32'h220);
        for (int k = 0; k < 6; k++) push(1'b0, 1'b1, "R6");
        end_write(6);

        // R4: duty above period gives full active period
        write_reg(4'h4, 32'd9);
        set_write(4'hC, 32'hC1);
        for (int k = 0; k < 12; k++) push(1'b1, 1'b0, "R4");
        end_write(12);

        // R7: gate bit forces low while running
        set_write(4'hC, 32'h89);
        for (int k = 0; k < 8; k++) push(1'b0, 1'b0, "R7");
        end_write(8);

        // R5: duty and period zero, invert set, constant low
        write_reg(4'h4, 32'd0);
        write_reg(4'h8, 32'd0);
        set_write(4'hC, 32'h2C1);
        for (int k = 0; k < 10; k++) push(1'b0, 1'b0, "R5");
        end_write(10);

        // R12: one-shot of period 4, duty 2
        write_reg(4'h4, 32'd2);
        write_reg(4'h8, 32'd4);
        set_write(4'hC, 32'hF1);
        for (int k = 0; k < 10; k++) push((k < 2), k >= 4, "R12");
        end_write(10);
        check_read(4'hC, 32'h70, "R12");

        // R10, R11: write-one-to-clear the flag drops irq
        write_reg(4'hC, 32'h60);
        @(negedge clk);
        check_port(irq, 1'b0, "R11");
        check_read(4'hC, 32'h20, "R10");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule